// File: doc/BRIEF.md
# LIN break generator and detector

This block adds break handling to an asynchronous serial line running in LIN mode. It contains two independent halves.

The master half sends a break. A one-cycle request makes it take over the transmit line and hold it low for a fixed number of bit times. It then drives a single high delimiter bit, hands the line back and pulses a done strobe. A request that arrives while the normal transmitter is still busy with a frame waits until that frame, stop bits included, has finished.

The slave half counts consecutive low receive samples. It samples only on the mid-bit strobe from the host receiver. Once the run reaches a selectable length, it sets a sticky flag. The same count drives a masking signal. This signal tells the ordinary receiver to ignore the framing error that a long low stretch would otherwise raise. The detector arms only after it has seen the line high, so one long low period produces one event. When LIN mode is off, both halves stay idle.

Top module: `lin_break_unit`

## Requirements
- R1: After a break starts, `tx_own`=1 with `tx_val`=0 for exactly 13 bit-tick periods. The transmit override outputs change only at clock edges where `bit_tick` is 1.
- R2: After the low period, the block drives one high delimiter bit (`tx_own`=1, `tx_val`=1). On the tick that closes the delimiter, `tx_own` returns to 0 and `brk_done` is high for exactly one clock.
- R3: `brk_flag` sets at the tick that samples the Nth consecutive low `rx_level`. N is 10 when `det_len11`=0 and 11 when `det_len11`=1.
- R4: A tick that samples `rx_level`=1 restarts the low-run count. A run shorter than N leaves `brk_flag` at 0.
- R5: `brk_flag` stays 1 until `flag_clr` is pulsed.
- R6: After a detection, and after reset, no new detection occurs until a tick has sampled `rx_level`=1. A continuing low line therefore does not set the flag again once it is cleared.
- R7: `fe_suppress` is 1 while the current low run is 9 or more ticks long. It returns to 0 after a tick that samples `rx_level`=1.
- R8: A `brk_req` pulse given while `frame_busy`=1 is held. The break starts on the first tick at which `frame_busy`=0.
- R9: With `lin_en`=0, `brk_req` is dropped and the detector is cleared. All outputs stay 0. A `brk_req` during a break in progress is ignored.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| lin_en | input | 1 | enables break handling |
| bit_tick | input | 1 | one-cycle strobe at each bit's mid-point sample |
| rx_level | input | 1 | receive line level |
| frame_busy | input | 1 | normal transmitter has a frame in progress |
| brk_req | input | 1 | send-break request pulse |
| det_len11 | input | 1 | 0: detect at 10 low bits, 1: at 11 |
| flag_clr | input | 1 | clears the break-detected flag |
| tx_own | output | 1 | block overrides the transmit line |
| tx_val | output | 1 | level driven while overriding |
| brk_done | output | 1 | break-plus-delimiter finished pulse |
| brk_flag | output | 1 | sticky break-detected flag |
| fe_suppress | output | 1 | mask framing errors in the normal receiver |

## Verification
The checker watches several rules on every cycle:
- the transmit override moves only on ticks;
- the low period, counted in ticks, equals the break length when the delimiter begins;
- the done strobe lasts one cycle and follows a delimiter;
- a flag rise always follows a low sampled tick;
- the flag stays set until cleared;
- disabling LIN mode idles everything;
- no break starts while a frame is busy.

Several behaviours need whole scenarios and are shown only by the bench:
- the exact 10 versus 11 threshold;
- the run reset on a high sample;
- the refusal to re-arm on a continued low line;
- the suppress threshold;
- the deferral of a request until a frame ends.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_WAIT  = 2'd1,
      TXS_LOW   = 2'd2,
      TXS_DELIM = 2'd3
   } brk_tx_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
   import lin_brk_pkg::*;
#(
   parameter int unsigned BRK_BITS   = 13,
   parameter int unsigned DELIM_BITS = 1,
   parameter int unsigned CNT_W      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lin_en,
   input  logic bit_tick,
   input  logic frame_busy,
   input  logic brk_req,
   output logic tx_own,
   output logic tx_val,
   output logic brk_done
);

   localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(BRK_BITS - 1);
   localparam logic [CNT_W-1:0] DELIM_LAST = CNT_W'(DELIM_BITS - 1);

   brk_tx_state_e    state_q;
   logic [CNT_W-1:0] bits_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         bits_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!lin_en) begin
            state_q <= TXS_IDLE;
            bits_q  <= '0;
         end else begin
            unique case (state_q)
               TXS_IDLE: begin
                  if (brk_req) state_q <= TXS_WAIT;
               end
               TXS_WAIT: begin
                  if (bit_tick && !frame_busy) begin
                     state_q <= TXS_LOW;
                     bits_q  <= '0;
                  end
               end
               TXS_LOW: begin
                  if (bit_tick) begin
                     if (bits_q == LOW_LAST) begin
                        state_q <= TXS_DELIM;
                        bits_q  <= '0;
                     end else begin
                        bits_q <= bits_q + 1'b1;
                     end
                  end
               end
               TXS_DELIM: begin
                  if (bit_tick) begin
                     if (bits_q == DELIM_LAST) begin
                        state_q <= TXS_IDLE;
                        bits_q  <= '0;
                        done_q  <= 1'b1;
                     end else begin
                        bits_q <= bits_q + 1'b1;
                     end
                  end
               end
               default: state_q <= TXS_IDLE;
            endcase
         end
      end
   end

   assign tx_own   = (state_q == TXS_LOW) || (state_q == TXS_DELIM);
   assign tx_val   = (state_q == TXS_DELIM);
   assign brk_done = done_q;

endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx #(
   parameter int unsigned DET_SHORT = 10,
   parameter int unsigned DET_LONG  = 11,
   parameter int unsigned CNT_W     = 4,
   parameter bit          CLR_WINS  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lin_en,
   input  logic bit_tick,
   input  logic rx_level,
   input  logic det_len11,
   input  logic flag_clr,
   output logic brk_flag,
   output logic fe_suppress
);

   localparam logic [CNT_W-1:0] RUN_MAX    = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(DET_SHORT - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(DET_LONG - 1);
   localparam logic [CNT_W-1:0] MASK_AT    = CNT_W'(DET_SHORT - 1);

   logic [CNT_W-1:0] run_q;
   logic             armed_q;
   logic             flag_q;
   logic             hit;
   logic             flag_nxt;
   logic [CNT_W-1:0] last_lo;

   assign last_lo = det_len11 ? LONG_LAST : SHORT_LAST;
   assign hit     = bit_tick && !rx_level && armed_q && (run_q == last_lo);

   generate
      if (CLR_WINS) begin : g_clr_first
         assign flag_nxt = flag_clr ? 1'b0 : (flag_q | hit);
      end else begin : g_set_first
         assign flag_nxt = hit | (flag_q & ~flag_clr);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else if (!lin_en) begin
         run_q   <= '0;
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         flag_q <= flag_nxt;
         if (bit_tick) begin
            if (rx_level) begin
               run_q   <= '0;
               armed_q <= 1'b1;
            end else begin
               if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
               if (hit) armed_q <= 1'b0;
            end
         end
      end
   end

   assign brk_flag    = flag_q;
   assign fe_suppress = lin_en && (run_q >= MASK_AT);

endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit
   import lin_brk_pkg::*;
#(
   parameter int unsigned BRK_BITS   = 13,
   parameter int unsigned DELIM_BITS = 1,
   parameter int unsigned DET_SHORT  = 10,
   parameter int unsigned DET_LONG   = 11,
   parameter bit          CLR_WINS   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lin_en,
   input  logic bit_tick,
   input  logic rx_level,
   input  logic frame_busy,
   input  logic brk_req,
   input  logic det_len11,
   input  logic flag_clr,
   output logic tx_own,
   output logic tx_val,
   output logic brk_done,
   output logic brk_flag,
   output logic fe_suppress
);

   localparam int unsigned TX_CNT_W = cnt_width(BRK_BITS > DELIM_BITS ? BRK_BITS : DELIM_BITS);
   localparam int unsigned RX_CNT_W = cnt_width(DET_LONG + 1);

   if (DET_SHORT < 2) begin : g_bad_short
      $error("DET_SHORT must be at least 2");
   end
   if (DET_LONG <= DET_SHORT) begin : g_bad_long
      $error("DET_LONG must exceed DET_SHORT");
   end
   if (DELIM_BITS < 1) begin : g_bad_delim
      $error("DELIM_BITS must be at least 1");
   end
   if (BRK_BITS <= DET_LONG) begin : g_bad_brk
      $error("BRK_BITS must exceed DET_LONG");
   end

   lin_brk_tx #(
      .BRK_BITS   (BRK_BITS),
      .DELIM_BITS (DELIM_BITS),
      .CNT_W      (TX_CNT_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .lin_en     (lin_en),
      .bit_tick   (bit_tick),
      .frame_busy (frame_busy),
      .brk_req    (brk_req),
      .tx_own     (tx_own),
      .tx_val     (tx_val),
      .brk_done   (brk_done)
   );

   lin_brk_rx #(
      .DET_SHORT (DET_SHORT),
      .DET_LONG  (DET_LONG),
      .CNT_W     (RX_CNT_W),
      .CLR_WINS  (CLR_WINS)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .lin_en      (lin_en),
      .bit_tick    (bit_tick),
      .rx_level    (rx_level),
      .det_len11   (det_len11),
      .flag_clr    (flag_clr),
      .brk_flag    (brk_flag),
      .fe_suppress (fe_suppress)
   );

endmodule

// File: rtl/lin_break_chk.sv
module lin_break_chk #(
   parameter int unsigned BRK_BITS = 13
) (
   input logic clk,
   input logic rst_n,
   input logic lin_en,
   input logic bit_tick,
   input logic rx_level,
   input logic frame_busy,
   input logic flag_clr,
   input logic tx_own,
   input logic tx_val,
   input logic brk_done,
   input logic brk_flag,
   input logic fe_suppress
);

   logic [7:0] low_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_ticks <= '0;
      end else if (!tx_own) begin
         low_ticks <= '0;
      end else if (!tx_val && bit_tick && low_ticks != 8'hFF) begin
         low_ticks <= low_ticks + 8'd1;
      end
   end

   AST_TX_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_en && !bit_tick) |=> ($stable(tx_own) && $stable(tx_val))); // R1

   AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_own && tx_val && !$past(tx_val)) |-> (low_ticks == 8'(BRK_BITS))); // R1

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |=> !brk_done); // R2

   AST_DONE_AFTER_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> ($past(tx_own && tx_val) && !tx_own)); // R2

   AST_FLAG_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> $past(bit_tick && !rx_level)); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !flag_clr && lin_en) |=> brk_flag); // R5

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_own) |-> $past(!frame_busy && bit_tick)); // R8

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lin_en |=> (!tx_own && !brk_flag && !brk_done && !fe_suppress)); // R9

endmodule

bind lin_break_unit lin_break_chk #(.BRK_BITS(BRK_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lin_en      (lin_en),
   .bit_tick    (bit_tick),
   .rx_level    (rx_level),
   .frame_busy  (frame_busy),
   .flag_clr    (flag_clr),
   .tx_own      (tx_own),
   .tx_val      (tx_val),
   .brk_done    (brk_done),
   .brk_flag    (brk_flag),
   .fe_suppress (fe_suppress)
);

// File: tb/tb_lin_break_unit.sv
module tb_lin_break_unit;

   localparam int CLK_P    = 10;
   localparam int TICK_GAP = 4;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n, lin_en, bit_tick, rx_level, frame_busy, brk_req, det_len11, flag_clr;
   logic tx_own, tx_val, brk_done, brk_flag, fe_suppress;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;

   always #(CLK_P / 2) clk = ~clk;

   lin_break_unit dut (
      .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .bit_tick(bit_tick),
      .rx_level(rx_level), .frame_busy(frame_busy), .brk_req(brk_req),
      .det_len11(det_len11), .flag_clr(flag_clr), .tx_own(tx_own),
      .tx_val(tx_val), .brk_done(brk_done), .brk_flag(brk_flag),
      .fe_suppress(fe_suppress)
   );

   function automatic logic exp_flag(input int run, input logic sel11);
      return run >= (sel11 ? 11 : 10);
   endfunction

   function automatic logic exp_mask(input int run);
      return run >= 9;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic tick(input logic rx);
      rx_level = rx;
      repeat (TICK_GAP - 1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic pulse_req();
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   // Runs a started break to completion and checks R1/R2 shape.
   task automatic run_break(input string tag, input bit extra_req);
      int lo_n = 0, hi_n = 0, done_n = 0, done_at = 0;
      for (int k = 1; k <= 16; k++) begin
         if (extra_req && k == 5) pulse_req();
         tick(1'b1);
         if (tx_own && !tx_val) lo_n++;
         if (tx_own && tx_val) hi_n++;
         if (brk_done) begin done_n++; done_at = k; end
      end
      chk({tag, " R1 low ticks"}, lo_n, 13);
      chk({tag, " R2 delimiter ticks"}, hi_n, 1);
      chk({tag, " R2 done count"}, done_n, 1);
      chk({tag, " R2 done position"}, done_at, 15);
   endtask

   initial begin
      for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; lin_en = 1'b1; bit_tick = 1'b0; rx_level = 1'b1;
      frame_busy = 1'b0; brk_req = 1'b0; det_len11 = 1'b0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 reset outputs", {tx_own, tx_val, brk_done, brk_flag, fe_suppress}, 0);

      // R6: after reset, detector not armed until a high sample
      for (int i = 0; i < 11; i++) tick(1'b0);
      chk("R6 no detect before first high", brk_flag, 0);
      tick(1'b1);

      // R3 exact threshold, 10 bits
      det_len11 = 1'b0;
      for (int i = 0; i < 8; i++) tick(1'b0);
      chk("R7 mask off after 8 lows", fe_suppress, 0);
      tick(1'b0);
      chk("R7 mask on after 9 lows", fe_suppress, 1);
      chk("R3 no flag after 9 lows", brk_flag, 0);
      tick(1'b0);
      chk("R3 flag after 10 lows", brk_flag, 1);
      tick(1'b0);
      chk("R5 flag held", brk_flag, 1);
      pulse_clr();
      chk("R5 flag cleared", brk_flag, 0);
      // R6: line still low, no re-arm
      for (int i = 0; i < 12; i++) tick(1'b0);
      chk("R6 no re-arm while low", brk_flag, 0);
      tick(1'b1);
      chk("R7 mask off after high", fe_suppress, 0);

      // R3 with 11-bit threshold
      det_len11 = 1'b1;
      for (int i = 0; i < 10; i++) tick(1'b0);
      chk("R3 sel11 no flag after 10", brk_flag, 0);
      tick(1'b0);
      chk("R3 sel11 flag after 11", brk_flag, 1);
      pulse_clr();
      tick(1'b1);

      // R4: high sample restarts run
      det_len11 = 1'b0;
      for (int i = 0; i < 7; i++) tick(1'b0);
      tick(1'b1);
      for (int i = 0; i < 7; i++) tick(1'b0);
      chk("R4 split run no flag", brk_flag, 0);
      tick(1'b1);

      // Random runs against the threshold model
      for (int it = 0; it < 40; it++) begin
         int run;
         int hi_pre;
         logic sel;
         run    = 5 + int'($urandom_range(9));
         hi_pre = 1 + int'($urandom_range(2));
         sel    = 1'($urandom_range(1));
         det_len11 = sel;
         for (int h = 0; h < hi_pre; h++) tick(1'b1);
         for (int l = 0; l < run; l++) tick(1'b0);
         chk($sformatf("R3 R4 random run=%0d sel=%0d", run, sel), brk_flag, exp_flag(run, sel));
         chk($sformatf("R7 random run=%0d", run), fe_suppress, exp_mask(run));
         pulse_clr();
         tick(1'b1);
      end

      // Break generation, idle frame, with a request during the break
      rx_level = 1'b1;
      pulse_req();
      run_break("basic", 1'b1);
      for (int i = 0; i < 3; i++) tick(1'b1);
      chk("R9 request during break ignored", tx_own, 0);

      // R8: request held while a frame is busy
      frame_busy = 1'b1;
      pulse_req();
      begin
         int own_n = 0;
         for (int i = 0; i < 3; i++) begin
            tick(1'b1);
            own_n += tx_own;
         end
         chk("R8 held while busy", own_n, 0);
      end
      frame_busy = 1'b0;
      run_break("deferred", 1'b0);

      // Random busy hold lengths
      for (int it = 0; it < 4; it++) begin
         int hold;
         int own_n = 0;
         hold = int'($urandom_range(3));
         frame_busy = (hold != 0);
         pulse_req();
         for (int i = 0; i < hold; i++) begin
            tick(1'b1);
            own_n += tx_own;
         end
         chk($sformatf("R8 random hold=%0d", hold), own_n, 0);
         frame_busy = 1'b0;
         run_break("random", 1'b0);
      end

      // R9: LIN mode off
      lin_en = 1'b0;
      pulse_req();
      begin
         int own_n = 0, done_n = 0;
         for (int i = 0; i < 15; i++) begin
            tick(1'b1);
            own_n += tx_own;
            done_n += brk_done;
         end
         chk("R9 no break when off", own_n + done_n, 0);
      end
      for (int i = 0; i < 12; i++) tick(1'b0);
      chk("R9 no detect when off", {brk_flag, fe_suppress}, 0);
      lin_en = 1'b1;
      tick(1'b1);
      chk("R9 idle after re-enable", tx_own, 0);

      summary();
   end

endmodule